// File: doc/BRIEF.md
# Host Register Access Bridge

This block lets an external host reach a small calculator over a narrow, slow, parallel-style bus. The host owns three strobe lines: read, write and clear. It also drives a select line and an input data bus, and it reads an output data bus. The strobes are asynchronous to the block clock. Each one is brought into the clock domain and edge-detected, so one pulse on a host line makes exactly one access.

A pointer register chooses which of four data registers later strobes act on. Writing with the select line high loads the pointer. Writing with the select line low stores into the register the pointer names. The four registers are:

- first operand;
- second operand;
- a control word that also carries a live busy flag from the arithmetic unit;
- the arithmetic result, which comes straight from the unit and cannot be written.

When a control write has its start bit set, the block sends one start pulse toward the arithmetic unit.

Top module: `host_reg_bridge`

## Requirements
- R1: After the synchronous reset `rst`, `host_dout`, `alu_op_a`, `alu_op_b` and `alu_ctrl` are zero and `alu_start` is low.
- R2: A write with `host_sel` high loads the pointer from `host_din[1:0]` and leaves all stored data registers unchanged.
- R3: A write with `host_sel` low stores `host_din` into the register the pointer names. Pointer 0 is the first operand (`alu_op_a`), 1 is the second operand (`alu_op_b`) and 2 is the control word (`alu_ctrl`).
- R4: A write to pointer 3 changes no register. A read of pointer 3 returns `alu_result` as it is at the clock edge of the read access.
- R5: A read of pointer 2 returns the stored control word, except that bit 7 is replaced by the `alu_busy` input.
- R6: Each rising edge of a host strobe causes exactly one access, however long the strobe stays high.
- R7: A strobe that rises before clock edge k takes effect at edge k+2. After edge k+1 the outputs still show their old values.
- R8: `host_dout` changes only on a read access or a clear access. Between these it holds its value even if `alu_result` or `alu_busy` changes.
- R9: A control write with bit 0 set drives `alu_start` high for exactly one cycle, starting at the same edge that updates `alu_ctrl`. A control write with bit 0 clear gives no pulse.
- R10: A clear access (rising `host_clr`) sets the pointer, the three stored registers and `host_dout` to zero.
- R11: When clear and write strobes rise together, the clear wins and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| host_rd | input | 1 | Asynchronous host read strobe |
| host_wr | input | 1 | Asynchronous host write strobe |
| host_clr | input | 1 | Asynchronous host clear strobe |
| host_sel | input | 1 | High: write loads pointer; low: write stores data |
| host_din | input | 8 | Host write data |
| host_dout | output | 8 | Registered read-back data |
| alu_op_a | output | 8 | First operand register |
| alu_op_b | output | 8 | Second operand register |
| alu_ctrl | output | 8 | Stored control word |
| alu_start | output | 1 | One-cycle start pulse |
| alu_result | input | 8 | Live result from arithmetic unit |
| alu_busy | input | 1 | Live busy flag from arithmetic unit |

## Verification
Every access lands two clock edges after the edge that first samples the rising strobe: one edge for the second synchronizer flop and one for the register update. The bench changes inputs on falling edges and holds each strobe for four cycles, then keeps it low for four. It samples results only after the strobe has dropped, well past the due edge.

One directed test counts edges exactly. It checks that the read-back data is still old after edge k+1 and new after edge k+2. A cycle counter on `alu_start` confirms that the pulse is exactly one cycle wide even with a long-held strobe.

// File: rtl/hrb_pkg.sv
package hrb_pkg;
  localparam int NUM_REGS = 4;
  localparam int ADDR_W   = $clog2(NUM_REGS);

  typedef enum logic [ADDR_W-1:0] {
    SLOT_OPA  = 2'd0,
    SLOT_OPB  = 2'd1,
    SLOT_CTRL = 2'd2,
    SLOT_RES  = 2'd3
  } slot_e;

  localparam int STB_RD  = 0;
  localparam int STB_WR  = 1;
  localparam int STB_CLR = 2;
  localparam int NUM_STB = 3;
endpackage

// File: rtl/hrb_edge_sync.sv
module hrb_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-1:0], async_in};
  end

  assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];

  // R6: a detected edge never lasts more than one cycle
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/hrb_reg_bank.sv
module hrb_reg_bank
  import hrb_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int START_BIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr,
  input  logic              sel,
  input  logic [DATA_W-1:0] din,
  output slot_e             ptr,
  output logic [DATA_W-1:0] op_a,
  output logic [DATA_W-1:0] op_b,
  output logic [DATA_W-1:0] ctrl,
  output logic              start
);
  localparam int NSTORE = NUM_REGS - 1;

  slot_e             ptr_q;
  logic [DATA_W-1:0] store_q [NSTORE];
  logic              start_q;
  logic              wr_data;

  assign wr_data = wr && !sel && !clr;

  always_ff @(posedge clk) begin
    if (rst || clr)      ptr_q <= SLOT_OPA;
    else if (wr && sel)  ptr_q <= slot_e'(din[ADDR_W-1:0]);
  end

  for (genvar gi = 0; gi < NSTORE; gi++) begin : g_store
    always_ff @(posedge clk) begin
      if (rst || clr)
        store_q[gi] <= '0;
      else if (wr_data && (ptr_q == slot_e'(gi)))
        store_q[gi] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) start_q <= 1'b0;
    else            start_q <= wr_data && (ptr_q == SLOT_CTRL) && din[START_BIT];
  end

  assign ptr   = ptr_q;
  assign op_a  = store_q[SLOT_OPA];
  assign op_b  = store_q[SLOT_OPB];
  assign ctrl  = store_q[SLOT_CTRL];
  assign start = start_q;

  // R2: pointer loads leave stored data alone
  a_r2_ptr_only: assert property (@(posedge clk) disable iff (rst)
    (wr && sel && !clr) |=> ($stable(op_a) && $stable(op_b) && $stable(ctrl)));
  // R3: data write to first operand slot lands there
  a_r3_opa_store: assert property (@(posedge clk) disable iff (rst)
    (wr_data && ptr_q == SLOT_OPA) |=> (op_a == $past(din)));
  // R4: write to result slot touches nothing
  a_r4_res_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_data && ptr_q == SLOT_RES) |=> ($stable(op_a) && $stable(op_b) && $stable(ctrl)));
  // R9: start is one cycle wide
  a_r9_start_width: assert property (@(posedge clk) disable iff (rst)
    start |=> !start);
  // R10: clear empties pointer and bank
  a_r10_bank_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> (ptr == SLOT_OPA && op_a == '0 && op_b == '0 && ctrl == '0 && !start));
endmodule

// File: rtl/hrb_readback.sv
module hrb_readback
  import hrb_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int BUSY_BIT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              rd,
  input  slot_e             ptr,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [DATA_W-1:0] ctrl,
  input  logic [DATA_W-1:0] result,
  input  logic              busy,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] status_w;
  logic [DATA_W-1:0] pick;
  logic [DATA_W-1:0] dout_q;

  always_comb begin
    status_w           = ctrl;
    status_w[BUSY_BIT] = busy;
  end

  always_comb begin
    unique case (ptr)
      SLOT_OPA:  pick = op_a;
      SLOT_OPB:  pick = op_b;
      SLOT_CTRL: pick = status_w;
      SLOT_RES:  pick = result;
      default:   pick = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clr) dout_q <= '0;
    else if (rd)    dout_q <= pick;
  end

  assign dout = dout_q;

  // R8: output holds between accesses
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !(rd || clr) |=> $stable(dout));
  // R10: clear zeroes the output
  a_r10_dout_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> (dout == '0));
  // R4: result slot reads the live input
  a_r4_res_read: assert property (@(posedge clk) disable iff (rst)
    (rd && !clr && ptr == SLOT_RES) |=> (dout == $past(result)));
endmodule

// File: rtl/host_reg_bridge.sv
module host_reg_bridge
  import hrb_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int START_BIT   = 0,
  parameter int BUSY_BIT    = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic              host_clr,
  input  logic              host_sel,
  input  logic [DATA_W-1:0] host_din,
  output logic [DATA_W-1:0] host_dout,
  output logic [DATA_W-1:0] alu_op_a,
  output logic [DATA_W-1:0] alu_op_b,
  output logic [DATA_W-1:0] alu_ctrl,
  output logic              alu_start,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              alu_busy
);
  logic [NUM_STB-1:0] stb_raw;
  logic [NUM_STB-1:0] stb_rise;
  slot_e              ptr;

  assign stb_raw[STB_RD]  = host_rd;
  assign stb_raw[STB_WR]  = host_wr;
  assign stb_raw[STB_CLR] = host_clr;

  for (genvar gs = 0; gs < NUM_STB; gs++) begin : g_sync
    hrb_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst      (rst),
      .async_in (stb_raw[gs]),
      .rise     (stb_rise[gs])
    );
  end

  hrb_reg_bank #(.DATA_W(DATA_W), .START_BIT(START_BIT)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .clr   (stb_rise[STB_CLR]),
    .wr    (stb_rise[STB_WR]),
    .sel   (host_sel),
    .din   (host_din),
    .ptr   (ptr),
    .op_a  (alu_op_a),
    .op_b  (alu_op_b),
    .ctrl  (alu_ctrl),
    .start (alu_start)
  );

  hrb_readback #(.DATA_W(DATA_W), .BUSY_BIT(BUSY_BIT)) u_rb (
    .clk    (clk),
    .rst    (rst),
    .clr    (stb_rise[STB_CLR]),
    .rd     (stb_rise[STB_RD]),
    .ptr    (ptr),
    .op_a   (alu_op_a),
    .op_b   (alu_op_b),
    .ctrl   (alu_ctrl),
    .result (alu_result),
    .busy   (alu_busy),
    .dout   (host_dout)
  );

  // R9: a start pulse only follows a write edge to the control slot
  a_r9_start_cause: assert property (@(posedge clk) disable iff (rst)
    alu_start |-> $past(stb_rise[STB_WR] && !host_sel && ptr == SLOT_CTRL && host_din[START_BIT]));
  // R11: clear overrides a simultaneous write
  a_r11_clr_wins: assert property (@(posedge clk) disable iff (rst)
    (stb_rise[STB_CLR] && stb_rise[STB_WR]) |=> (alu_op_a == '0 && alu_op_b == '0 && alu_ctrl == '0));
endmodule

// File: tb/sim_host_reg_bridge.sv
module sim_host_reg_bridge;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_rd = 1'b0, host_wr = 1'b0, host_clr = 1'b0, host_sel = 1'b0;
  logic [7:0] host_din = '0;
  logic [7:0] host_dout, alu_op_a, alu_op_b, alu_ctrl;
  logic       alu_start;
  logic [7:0] alu_result = 8'hC3;
  logic       alu_busy = 1'b0;

  int n_chk = 0, n_fail = 0, start_cnt = 0;

  always #2 clk = ~clk;

  host_reg_bridge u0 (
    .clk(clk), .rst(rst), .host_rd(host_rd), .host_wr(host_wr), .host_clr(host_clr),
    .host_sel(host_sel), .host_din(host_din), .host_dout(host_dout),
    .alu_op_a(alu_op_a), .alu_op_b(alu_op_b), .alu_ctrl(alu_ctrl),
    .alu_start(alu_start), .alu_result(alu_result), .alu_busy(alu_busy)
  );

  always @(posedge clk) if (alu_start) start_cnt <= start_cnt + 1;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_op(input logic sel, input logic [7:0] d);
    @(negedge clk);
    host_sel = sel; host_din = d; host_wr = 1'b1;
    idle(4);
    host_wr = 1'b0;
    idle(4);
  endtask

  task automatic rd_op();
    @(negedge clk);
    host_rd = 1'b1;
    idle(4);
    host_rd = 1'b0;
    idle(4);
  endtask

  task automatic clr_op();
    @(negedge clk);
    host_clr = 1'b1;
    idle(4);
    host_clr = 1'b0;
    idle(4);
  endtask

  // kind: 0 pointer write, 1 data write, 2 read and compare
  localparam logic [17:0] VEC [20] = '{
    {2'd0, 8'h00, 8'h00}, {2'd1, 8'h12, 8'h00},
    {2'd0, 8'h01, 8'h00}, {2'd1, 8'h34, 8'h00},
    {2'd0, 8'h02, 8'h00}, {2'd1, 8'h06, 8'h00},
    {2'd0, 8'h03, 8'h00}, {2'd1, 8'hFF, 8'h00},
    {2'd2, 8'h00, 8'hC3}, {2'd0, 8'h00, 8'h00},
    {2'd2, 8'h00, 8'h12}, {2'd0, 8'h01, 8'h00},
    {2'd2, 8'h00, 8'h34}, {2'd0, 8'h02, 8'h00},
    {2'd2, 8'h00, 8'h06}, {2'd0, 8'h00, 8'h00},
    {2'd1, 8'hA5, 8'h00}, {2'd2, 8'h00, 8'hA5},
    {2'd0, 8'h01, 8'h00}, {2'd2, 8'h00, 8'h34}
  };

  initial begin
    #(4 * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    check("R1 dout", host_dout, 8'h00);
    check("R1 op_a", alu_op_a, 8'h00);
    check("R1 op_b", alu_op_b, 8'h00);
    check("R1 ctrl", alu_ctrl, 8'h00);
    check("R1 start", {7'd0, alu_start}, 8'h00);

    // R3 R4 table walk
    for (int v = 0; v < 20; v++) begin
      case (VEC[v][17:16])
        2'd0: wr_op(1'b1, VEC[v][15:8]);
        2'd1: wr_op(1'b0, VEC[v][15:8]);
        default: begin
          rd_op();
          check($sformatf("R3/R4 vector %0d", v), host_dout, VEC[v][7:0]);
        end
      endcase
    end
    check("R3 op_a", alu_op_a, 8'hA5);
    check("R3 op_b", alu_op_b, 8'h34);
    check("R4 ctrl untouched by result write", alu_ctrl, 8'h06);
    check("R9 no start for bit0 clear", start_cnt[7:0], 8'h00);

    // R2 pointer write leaves data alone
    wr_op(1'b1, 8'h02);
    check("R2 op_a", alu_op_a, 8'hA5);
    check("R2 op_b", alu_op_b, 8'h34);
    check("R2 ctrl", alu_ctrl, 8'h06);

    // R5 busy flag in bit 7
    alu_busy = 1'b1;
    rd_op();
    check("R5 status busy", host_dout, 8'h86);
    alu_busy = 1'b0;

    // R9 R6 long strobe with start bit
    start_cnt = 0;
    @(negedge clk);
    host_sel = 1'b0; host_din = 8'h01; host_wr = 1'b1;
    idle(12);
    host_wr = 1'b0;
    idle(4);
    check("R6/R9 single start pulse", start_cnt[7:0], 8'h01);
    check("R9 ctrl stored", alu_ctrl, 8'h01);

    // R8 hold between reads
    wr_op(1'b1, 8'h03);
    alu_result = 8'h11;
    rd_op();
    check("R4 live result", host_dout, 8'h11);
    alu_result = 8'h77;
    alu_busy = 1'b1;
    idle(6);
    check("R8 dout held", host_dout, 8'h11);
    alu_busy = 1'b0;

    // R7 exact latency
    wr_op(1'b1, 8'h01);
    wr_op(1'b0, 8'h5A);
    @(negedge clk);
    host_rd = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R7 old after k+1", host_dout, 8'h11);
    @(negedge clk);
    check("R7 new after k+2", host_dout, 8'h5A);
    idle(3);
    host_rd = 1'b0;
    idle(4);

    // R10 clear
    clr_op();
    check("R10 op_a", alu_op_a, 8'h00);
    check("R10 op_b", alu_op_b, 8'h00);
    check("R10 ctrl", alu_ctrl, 8'h00);
    check("R10 dout", host_dout, 8'h00);
    wr_op(1'b0, 8'h3C);
    check("R10 pointer reset to 0", alu_op_a, 8'h3C);
    check("R10 op_b still 0", alu_op_b, 8'h00);

    // R11 clear wins over write
    @(negedge clk);
    host_sel = 1'b0; host_din = 8'h99; host_wr = 1'b1; host_clr = 1'b1;
    idle(4);
    host_wr = 1'b0; host_clr = 1'b0;
    idle(4);
    check("R11 write dropped", alu_op_a, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule